// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes a trap request from a hart's pipeline and decides which privilege level services it: supervisor or machine. It then updates, in one clock, the architectural state that belongs to that level. The request carries a cause, the faulting PC, an optional faulting address and a flag that says whether that address is valid. Routing to supervisor depends on three things: the current privilege, whether the cause is an interrupt (the top cause bit) and the matching bit of the interrupt or exception delegation mask. The delegation masks and the supervisor vector base are inputs.

On entry the unit loads the handler PC. It writes the target level's cause, saved-PC and faulting-address registers. It stacks the interrupt-enable bit of the old privilege into the target's previous-enable bit and records the old privilege in the target's previous-privilege field. It clears the target's enable bit and switches the current privilege. Every trap also cancels a pending load reservation and emits a one-cycle translation-flush pulse. A small load port lets the surrounding logic, such as return-from-trap sequencing, set the privilege and the enable bits. The same port is how the bench reaches every starting state.

Top module: `trap_entry_unit`

## Requirements
- R1: While rst_ni is low, and until the first update after it rises, priv_o is 3 (machine), pc_o equals RESET_PC, and every other output is 0.
- R2: When cause bit XLEN-1 is set, the cause is an interrupt and its delegation bit is taken from mideleg_i at index cause[XLEN-2:0]. Otherwise the cause is an exception and the bit is taken from medeleg_i at index cause.
- R3: A trap is handled in supervisor only if priv_o is 0 or 1 before the trap, the cause index (top bit cleared) is below XLEN and the selected delegation bit is 1. Otherwise it is handled in machine.
- R4: On a supervisor trap the unit makes the following updates. pc_o gets stvec_i with bits [1:0] forced to 0. scause_o gets the whole cause and sepc_o gets the trap PC. sbadaddr_o gets the bad address only when has-bad-address is 1. The machine cause, PC and address registers keep their values.
- R5: On a machine trap pc_o gets MTVEC. mcause_o, mepc_o and mbadaddr_o are written under the same rules as in R4, and the supervisor registers keep their values.
- R6: ie_o holds the enable bits: bit 0 user, bit 1 supervisor, bit 3 machine, bit 2 always 0. On a trap the target's previous-enable bit (spie_o or mpie_o) gets ie_o[old priv]. The target's enable bit (bit 1 or bit 3) is cleared, and the other enable bits keep their values.
- R7: On a supervisor trap spp_o gets bit 0 of the old privilege. On a machine trap mpp_o gets the old privilege.
- R8: After a trap priv_o is 1 or 3, matching the handler. flush_o is high for exactly the cycle after each trap, and after each load that changes the privilege.
- R9: A trap clears resv_o. resv_set_i sets resv_o one cycle later, but only in a cycle with no trap.
- R10: When ld_en_i is high with no trap, ie_o takes ld_ie_i (with bit 2 forced to 0) and priv_o takes ld_priv_i. A ld_priv_i of 2 is ignored. A load in the same cycle as a trap is ignored.
- R11: All results appear one clock after the strobe. In a cycle with no trap, no load and no reservation set, no output changes and flush_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap strobe |
| trap_cause_i | input | XLEN | Cause, top bit marks an interrupt |
| trap_epc_i | input | XLEN | PC of the trapping instruction |
| trap_badaddr_i | input | XLEN | Faulting address |
| trap_has_bad_i | input | 1 | Faulting address is valid |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor vector base |
| ld_en_i | input | 1 | Load privilege and enable bits |
| ld_priv_i | input | 2 | Privilege to load |
| ld_ie_i | input | 4 | Enable bits to load |
| resv_set_i | input | 1 | Set the load reservation |
| priv_o | output | 2 | Current privilege |
| pc_o | output | XLEN | Handler PC |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor saved PC |
| sbadaddr_o | output | XLEN | Supervisor faulting address |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine saved PC |
| mbadaddr_o | output | XLEN | Machine faulting address |
| ie_o | output | 4 | Enable bits per privilege |
| spie_o | output | 1 | Supervisor previous enable |
| mpie_o | output | 1 | Machine previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mpp_o | output | 2 | Machine previous privilege |
| resv_o | output | 1 | Load reservation valid |
| flush_o | output | 1 | Translation flush pulse |

## Verification
Every result is registered once, so every output reflects the inputs applied exactly one rising edge earlier. flush_o is high only in that single following cycle. The bench drives each stimulus at a falling edge and moves its reference model forward by one step at the same time. At the next falling edge it compares every output with the model. This catches results that appear too late as well as results that appear too early, with no skew allowance.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_R = 2'd2;
  localparam logic [1:0] PRV_M = 2'd3;
endpackage

// File: rtl/trap_route.sv
module trap_route #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  output logic            to_s_o
);
  import trap_pkg::*;
  localparam int IW = $clog2(XLEN);

  logic            is_irq;
  logic            in_range;
  logic [XLEN-1:0] dmask;
  logic [IW-1:0]   idx;

  always_comb begin
    is_irq   = cause_i[XLEN-1];
    // index below XLEN iff every bit above the index field is zero (top bit excluded)
    in_range = (cause_i[XLEN-2:IW] == '0);
    idx      = cause_i[IW-1:0];
    dmask    = is_irq ? mideleg_i : medeleg_i;
    to_s_o   = (priv_i <= PRV_S) && in_range && dmask[idx];
  end
endmodule

// File: rtl/trap_state.sv
module trap_state #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [XLEN-1:0] MTVEC    = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_valid_i,
  input  logic            to_s_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] badaddr_i,
  input  logic            has_bad_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic            ld_en_i,
  input  logic [1:0]      ld_priv_i,
  input  logic [3:0]      ld_ie_i,
  input  logic            resv_set_i,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] sbad_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mbad_o,
  output logic [3:0]      ie_o,
  output logic            spie_o,
  output logic            mpie_o,
  output logic            spp_o,
  output logic [1:0]      mpp_o,
  output logic            resv_o,
  output logic            flush_o
);
  import trap_pkg::*;

  logic [1:0]      priv_q;
  logic [XLEN-1:0] pc_q, scause_q, sepc_q, sbad_q, mcause_q, mepc_q, mbad_q;
  logic [3:0]      ie_q;
  logic            spie_q, mpie_q, spp_q, resv_q, flush_q;
  logic [1:0]      mpp_q;
  logic            old_ie;
  logic            ld_priv_ok;

  always_comb begin
    old_ie     = ie_q[priv_q];
    ld_priv_ok = (ld_priv_i != PRV_R) && (ld_priv_i != priv_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q   <= PRV_M;
      pc_q     <= RESET_PC;
      scause_q <= '0;
      sepc_q   <= '0;
      sbad_q   <= '0;
      mcause_q <= '0;
      mepc_q   <= '0;
      mbad_q   <= '0;
      ie_q     <= '0;
      spie_q   <= 1'b0;
      mpie_q   <= 1'b0;
      spp_q    <= 1'b0;
      mpp_q    <= '0;
      resv_q   <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      if (trap_valid_i) begin
        flush_q <= 1'b1;
        resv_q  <= 1'b0;
        if (to_s_i) begin
          priv_q   <= PRV_S;
          pc_q     <= {stvec_i[XLEN-1:2], 2'b00};
          scause_q <= cause_i;
          sepc_q   <= epc_i;
          if (has_bad_i) sbad_q <= badaddr_i;
          spie_q   <= old_ie;
          spp_q    <= priv_q[0];
          ie_q[1]  <= 1'b0;
        end else begin
          priv_q   <= PRV_M;
          pc_q     <= MTVEC;
          mcause_q <= cause_i;
          mepc_q   <= epc_i;
          if (has_bad_i) mbad_q <= badaddr_i;
          mpie_q   <= old_ie;
          mpp_q    <= priv_q;
          ie_q[3]  <= 1'b0;
        end
      end else begin
        if (ld_en_i) begin
          ie_q <= {ld_ie_i[3], 1'b0, ld_ie_i[1:0]};
          if (ld_priv_ok) begin
            priv_q  <= ld_priv_i;
            flush_q <= 1'b1;
          end
        end
        if (resv_set_i) resv_q <= 1'b1;
      end
    end
  end

  assign priv_o   = priv_q;
  assign pc_o     = pc_q;
  assign scause_o = scause_q;
  assign sepc_o   = sepc_q;
  assign sbad_o   = sbad_q;
  assign mcause_o = mcause_q;
  assign mepc_o   = mepc_q;
  assign mbad_o   = mbad_q;
  assign ie_o     = ie_q;
  assign spie_o   = spie_q;
  assign mpie_o   = mpie_q;
  assign spp_o    = spp_q;
  assign mpp_o    = mpp_q;
  assign resv_o   = resv_q;
  assign flush_o  = flush_q;

  p_target_priv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (priv_q == PRV_S) || (priv_q == PRV_M));
  p_flush_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> flush_q);
  p_resv_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> !resv_q);
  p_target_ie_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> !ie_q[priv_q]);
  p_mach_from_mach_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_q == PRV_M) |=> priv_q == PRV_M);
  p_mpp_old_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !to_s_i) |=> mpp_q == $past(priv_q));
  p_idle_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_valid_i && !ld_en_i) |=> $stable(pc_q) && $stable(priv_q) && !flush_q);
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h0000_1000),
  parameter logic [XLEN-1:0] MTVEC    = XLEN'(32'h0000_0100)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_valid_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_epc_i,
  input  logic [XLEN-1:0] trap_badaddr_i,
  input  logic            trap_has_bad_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic            ld_en_i,
  input  logic [1:0]      ld_priv_i,
  input  logic [3:0]      ld_ie_i,
  input  logic            resv_set_i,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] sbadaddr_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mbadaddr_o,
  output logic [3:0]      ie_o,
  output logic            spie_o,
  output logic            mpie_o,
  output logic            spp_o,
  output logic [1:0]      mpp_o,
  output logic            resv_o,
  output logic            flush_o
);
  logic to_s;

  trap_route #(.XLEN(XLEN)) u_route (
    .cause_i   (trap_cause_i),
    .priv_i    (priv_o),
    .medeleg_i (medeleg_i),
    .mideleg_i (mideleg_i),
    .to_s_o    (to_s)
  );

  trap_state #(.XLEN(XLEN), .RESET_PC(RESET_PC), .MTVEC(MTVEC)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trap_valid_i (trap_valid_i),
    .to_s_i       (to_s),
    .cause_i      (trap_cause_i),
    .epc_i        (trap_epc_i),
    .badaddr_i    (trap_badaddr_i),
    .has_bad_i    (trap_has_bad_i),
    .stvec_i      (stvec_i),
    .ld_en_i      (ld_en_i),
    .ld_priv_i    (ld_priv_i),
    .ld_ie_i      (ld_ie_i),
    .resv_set_i   (resv_set_i),
    .priv_o       (priv_o),
    .pc_o         (pc_o),
    .scause_o     (scause_o),
    .sepc_o       (sepc_o),
    .sbad_o       (sbadaddr_o),
    .mcause_o     (mcause_o),
    .mepc_o       (mepc_o),
    .mbad_o       (mbadaddr_o),
    .ie_o         (ie_o),
    .spie_o       (spie_o),
    .mpie_o       (mpie_o),
    .spp_o        (spp_o),
    .mpp_o        (mpp_o),
    .resv_o       (resv_o),
    .flush_o      (flush_o)
  );
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] RESET_PC = 32'h0000_1000;
  localparam logic [XLEN-1:0] MTVEC    = 32'h0000_0100;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            trap_valid_i = 0, trap_has_bad_i = 0, ld_en_i = 0, resv_set_i = 0;
  logic [XLEN-1:0] trap_cause_i = 0, trap_epc_i = 0, trap_badaddr_i = 0;
  logic [XLEN-1:0] medeleg_i = 0, mideleg_i = 0, stvec_i = 0;
  logic [1:0]      ld_priv_i = 0;
  logic [3:0]      ld_ie_i = 0;
  logic [1:0]      priv_o, mpp_o;
  logic [XLEN-1:0] pc_o, scause_o, sepc_o, sbadaddr_o, mcause_o, mepc_o, mbadaddr_o;
  logic [3:0]      ie_o;
  logic            spie_o, mpie_o, spp_o, resv_o, flush_o;

  trap_entry_unit #(.XLEN(XLEN), .RESET_PC(RESET_PC), .MTVEC(MTVEC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .trap_valid_i(trap_valid_i), .trap_cause_i(trap_cause_i),
    .trap_epc_i(trap_epc_i), .trap_badaddr_i(trap_badaddr_i), .trap_has_bad_i(trap_has_bad_i),
    .medeleg_i(medeleg_i), .mideleg_i(mideleg_i), .stvec_i(stvec_i), .ld_en_i(ld_en_i),
    .ld_priv_i(ld_priv_i), .ld_ie_i(ld_ie_i), .resv_set_i(resv_set_i), .priv_o(priv_o),
    .pc_o(pc_o), .scause_o(scause_o), .sepc_o(sepc_o), .sbadaddr_o(sbadaddr_o),
    .mcause_o(mcause_o), .mepc_o(mepc_o), .mbadaddr_o(mbadaddr_o), .ie_o(ie_o),
    .spie_o(spie_o), .mpie_o(mpie_o), .spp_o(spp_o), .mpp_o(mpp_o), .resv_o(resv_o),
    .flush_o(flush_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  logic [1:0]      m_priv = 2'd3, m_mpp = 0;
  logic [XLEN-1:0] m_pc = RESET_PC, m_scause = 0, m_sepc = 0, m_sbad = 0;
  logic [XLEN-1:0] m_mcause = 0, m_mepc = 0, m_mbad = 0;
  logic [3:0]      m_ie = 0;
  logic            m_spie = 0, m_mpie = 0, m_spp = 0, m_resv = 0, m_flush = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 R8 R10", "priv", priv_o, m_priv);
    chk("R4 R5 R11", "pc", pc_o, m_pc);
    chk("R4", "scause", scause_o, m_scause);
    chk("R4", "sepc", sepc_o, m_sepc);
    chk("R4", "sbad", sbadaddr_o, m_sbad);
    chk("R5", "mcause", mcause_o, m_mcause);
    chk("R5", "mepc", mepc_o, m_mepc);
    chk("R5", "mbad", mbadaddr_o, m_mbad);
    chk("R6 R10", "ie", ie_o, m_ie);
    chk("R6", "spie", spie_o, m_spie);
    chk("R6", "mpie", mpie_o, m_mpie);
    chk("R7", "spp", spp_o, m_spp);
    chk("R7", "mpp", mpp_o, m_mpp);
    chk("R9", "resv", resv_o, m_resv);
    chk("R8 R11", "flush", flush_o, m_flush);
  endtask

  // drive one stimulus, advance the model, compare one edge later
  task automatic cycle(bit tv, logic [XLEN-1:0] cause, logic [XLEN-1:0] epc,
                       logic [XLEN-1:0] bad, bit hb, bit le, logic [1:0] lp,
                       logic [3:0] li, bit rs);
    bit              to_s;
    bit              old_ie;
    logic [XLEN-1:0] dmask;
    longint unsigned idx;
    trap_valid_i = tv; trap_cause_i = cause; trap_epc_i = epc; trap_badaddr_i = bad;
    trap_has_bad_i = hb; ld_en_i = le; ld_priv_i = lp; ld_ie_i = li; resv_set_i = rs;
    m_flush = 0;
    if (tv) begin
      idx   = longint'(cause) & ~(64'd1 << (XLEN-1));
      dmask = cause[XLEN-1] ? mideleg_i : medeleg_i;
      to_s  = (m_priv <= 1) && (idx < XLEN) && dmask[idx[4:0]];
      old_ie = m_ie[m_priv];
      m_flush = 1; m_resv = 0;
      if (to_s) begin
        m_pc = stvec_i & ~32'd3; m_scause = cause; m_sepc = epc;
        if (hb) m_sbad = bad;
        m_spie = old_ie; m_spp = m_priv[0]; m_ie[1] = 0; m_priv = 1;
      end else begin
        m_pc = MTVEC; m_mcause = cause; m_mepc = epc;
        if (hb) m_mbad = bad;
        m_mpie = old_ie; m_mpp = m_priv; m_ie[3] = 0; m_priv = 3;
      end
    end else begin
      if (le) begin
        m_ie = li; m_ie[2] = 0;
        if (lp != 2 && lp != m_priv) begin m_priv = lp; m_flush = 1; end
      end
      if (rs) m_resv = 1;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "priv", priv_o, 2'd3);
    chk("R1", "pc", pc_o, RESET_PC);
    chk("R1", "ie", ie_o, 0);
    chk("R1", "flush", flush_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    compare_all();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);                        // R11 idle
    medeleg_i = 32'h0000_0100; mideleg_i = 32'h0000_0000; stvec_i = 32'h8000_0207;
    cycle(0, 0, 0, 0, 0, 1, 2'd0, 4'b1111, 0);               // R10 load user, bit2 forced 0
    cycle(1, 32'd8, 32'h400, 32'hdead, 1, 0, 0, 0, 0);       // R3 R4 user ecall to S, stvec low bits dropped
    cycle(1, 32'd8, 32'h404, 32'hbeef, 0, 0, 0, 0, 0);       // R4 sbad kept without has_bad
    mideleg_i = 32'h0000_0020; medeleg_i = 32'h0000_0000;
    cycle(0, 0, 0, 0, 0, 1, 2'd1, 4'b1010, 0);               // R10
    cycle(1, 32'h8000_0005, 32'h500, 0, 0, 0, 0, 0, 0);      // R2 interrupt via mideleg
    mideleg_i = 32'h0; medeleg_i = 32'h0000_0020;
    cycle(1, 32'h8000_0005, 32'h504, 32'h77, 1, 0, 0, 0, 0); // R2 mideleg clear -> M
    medeleg_i = '1; mideleg_i = '1;
    cycle(1, 32'd2, 32'h600, 32'h11, 1, 0, 0, 0, 0);         // R3 from M stays M
    cycle(0, 0, 0, 0, 0, 1, 2'd0, 4'b1001, 0);
    cycle(1, 32'd40, 32'h700, 0, 0, 0, 0, 0, 0);             // R3 index >= XLEN -> M
    cycle(0, 0, 0, 0, 0, 1, 2'd1, 4'b1011, 0);
    cycle(1, 32'h8000_0064, 32'h704, 0, 0, 0, 0, 0, 0);      // R3 large interrupt index -> M
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1);                        // R9 set reservation
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(1, 32'd3, 32'h800, 0, 0, 0, 0, 0, 1);              // R9 trap beats set
    cycle(0, 0, 0, 0, 0, 1, 2'd2, 4'b0001, 0);               // R10 priv 2 ignored
    cycle(1, 32'd3, 32'h804, 0, 0, 1, 2'd0, 4'b1111, 0);     // R10 load with trap ignored
    cycle(0, 0, 0, 0, 0, 1, 2'd3, 4'b1000, 0);               // R8 load same priv: no flush
    for (int i = 0; i < 3000; i++) begin
      logic [XLEN-1:0] c;
      if ($urandom_range(0, 7) == 0) begin
        medeleg_i = $urandom; mideleg_i = $urandom; stvec_i = $urandom;
      end
      c = $urandom_range(0, 3) == 0 ? $urandom : XLEN'($urandom_range(0, 40));
      if ($urandom_range(0, 1) == 0) c[XLEN-1] = 1'b1;
      cycle($urandom_range(0, 2) == 0, c, $urandom, $urandom, 1'($urandom),
            1'($urandom), 2'($urandom), 4'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule